// File: doc/BRIEF.md
# Packed Vector Lane Select and Destination Merge

This block surrounds an array of 64-bit lane adders for a packed double-precision add. From the encoding class, vector length, source flags and writemask controls it builds the operand pair that each lane adder sees. It also selects the rounding-control field that the adders use. The per-lane sums come back from the adders in the same cycle. The block then assembles the full 512-bit destination register from those sums, the old destination contents and zeros.

Each lane takes one of three values: its sum, its old destination value, or zero. The choice depends on the active lane count, the writemask and its enable, the merge or zero mode, and the encoding class. In the legacy class the old destination is also the first source and its upper bits are kept. In the other classes every bit above the vector length is cleared. A memory second source with broadcast gives the low 64-bit element of the second source to every lane. The destination is registered and appears one cycle after an input pulse, together with a valid strobe.

Top module: `vec_lane_merge`

## Requirements
- R1: The vector length code sets the active lane count. Code 0 gives 2 lanes, code 1 gives 4 lanes, and codes 2 and 3 give 8 lanes. Lane j is bits j*64+63..j*64. In the legacy class the count is always 2. Mask bits of lanes beyond the count have no effect.
- R2: An active lane takes its sum when its writemask bit is 1, or when the writemask is not in use. The writemask is in use only for the EVEX class (code 2) with the mask enable set.
- R3: When the writemask is in use and the mask bit of an active lane is 0, merge mode (zero select 0) keeps that lane's old destination value.
- R4: When the writemask is in use and the mask bit of an active lane is 0, zero mode (zero select 1) writes zero to that lane.
- R5: The VEX class (code 1, and the unused code 3) ignores the writemask and the mask enable. Every active lane takes its sum.
- R6: For the EVEX class with the memory-source flag and the broadcast flag both set, every lane's second operand is second-source bits 63:0.
- R7: For the VEX and EVEX classes, every destination bit above the active length, up to bit 511, is zero.
- R8: For the legacy class (code 0), the first operand of each lane is the old destination. Bits 511:128 of the old destination pass to the output unmodified. The writemask is ignored.
- R9: The rounding select equals the embedded field only when all of these hold: EVEX class, register-source flag set, length code 2 or 3, and broadcast set. In every other case it equals the global field. Encoding: 00 nearest-even, 01 toward negative, 10 toward positive, 11 toward zero.
- R10: The destination and the valid strobe update on the clock edge after an input valid pulse. With no pulse, the strobe is 0 and the destination holds.
- R11: Synchronous reset clears the destination and the valid strobe.
- R12: Outside the legacy class, the first operand of lane j is its first-source slice. Outside the EVEX memory-broadcast case, the second operand of lane j is its second-source slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pulse that captures a new destination |
| vlen | input | 2 | Vector length code |
| enc | input | 2 | Encoding class: 0 legacy, 1 VEX, 2 EVEX |
| bcast | input | 1 | Broadcast flag |
| mem_src | input | 1 | Second source comes from memory |
| reg_src | input | 1 | Second source is a register |
| wmask | input | 8 | Per-lane writemask |
| mask_en | input | 1 | Writemask in use |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| rc_global | input | 2 | Global rounding-control field |
| rc_embed | input | 2 | Embedded rounding-control field |
| src_a | input | 512 | First source |
| src_b | input | 512 | Second source |
| old_dst | input | 512 | Previous destination contents |
| lane_sum | input | 512 | Per-lane sums from the adders |
| op_a | output | 512 | First operand of each lane adder |
| op_b | output | 512 | Second operand of each lane adder |
| rc_sel | output | 2 | Selected rounding control |
| dst | output | 512 | Registered destination |
| out_valid | output | 1 | Destination valid strobe |

## Verification
The assertions check these behaviours on every cycle:
- the strobe follows the input pulse, and the destination holds between pulses;
- the legacy upper bits pass through;
- the upper bits clear at 128-bit length outside the legacy class;
- lane 0 is zeroed in zero mode;
- the broadcast operand reaches the top lane;
- the global rounding field is selected without a register source.

Only the bench scenarios can show the rest:
- the complete choice per lane across random masks, all three lengths and all classes;
- that mask bits of inactive lanes and the VEX writemask have no effect;
- the exact conditions under which the embedded rounding field is chosen.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  typedef enum logic [1:0] {
    PICK_SUM  = 2'd0,
    PICK_OLD  = 2'd1,
    PICK_ZERO = 2'd2
  } pick_e;
endpackage

// File: rtl/lane_operand_sel.sv
module lane_operand_sel #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic             legacy,
  input  logic             splat_b,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] old_dst,
  output logic [VEC_W-1:0] op_a,
  output logic [VEC_W-1:0] op_b
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign op_a[j*LANE_W +: LANE_W] = legacy ? old_dst[j*LANE_W +: LANE_W]
                                             : src_a[j*LANE_W +: LANE_W];
    assign op_b[j*LANE_W +: LANE_W] = splat_b ? src_b[LANE_W-1:0]
                                              : src_b[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lane_rc_select.sv
module lane_rc_select (
  input  logic [1:0] enc,
  input  logic [1:0] vlen,
  input  logic       reg_src,
  input  logic       bcast,
  input  logic [1:0] rc_global,
  input  logic [1:0] rc_embed,
  output logic [1:0] rc_sel
);
  import lane_pkg::*;
  logic use_embed;

  always_comb begin
    use_embed = (enc_e'(enc) == ENC_EVEX) && reg_src && vlen[1] && bcast;
    rc_sel    = use_embed ? rc_embed : rc_global;
  end
endmodule

// File: rtl/lane_dest_merge.sv
module lane_dest_merge #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  localparam int VEC_W = LANES * LANE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0] n_active,
  input  logic             legacy,
  input  logic             mask_use,
  input  logic             zero_mode,
  input  logic [LANES-1:0] wmask,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [VEC_W-1:0] lane_sum,
  output logic [VEC_W-1:0] next_dst
);
  import lane_pkg::*;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    pick_e pick;
    always_comb begin
      if (CNT_W'(j) >= n_active)
        pick = legacy ? PICK_OLD : PICK_ZERO;
      else if (!mask_use || wmask[j])
        pick = PICK_SUM;
      else
        pick = zero_mode ? PICK_ZERO : PICK_OLD;
    end

    always_comb begin
      unique case (pick)
        PICK_SUM: next_dst[j*LANE_W +: LANE_W] = lane_sum[j*LANE_W +: LANE_W];
        PICK_OLD: next_dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
        default:  next_dst[j*LANE_W +: LANE_W] = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_lane_merge.sv
module vec_lane_merge #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  localparam int VEC_W = LANES * LANE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       vlen,
  input  logic [1:0]       enc,
  input  logic             bcast,
  input  logic             mem_src,
  input  logic             reg_src,
  input  logic [LANES-1:0] wmask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [1:0]       rc_global,
  input  logic [1:0]       rc_embed,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [VEC_W-1:0] lane_sum,
  output logic [VEC_W-1:0] op_a,
  output logic [VEC_W-1:0] op_b,
  output logic [1:0]       rc_sel,
  output logic [VEC_W-1:0] dst,
  output logic             out_valid
);
  import lane_pkg::*;

  logic             legacy, evex, splat_b, mask_use;
  logic [CNT_W-1:0] n_active;
  logic [VEC_W-1:0] next_dst;

  always_comb begin
    legacy   = enc_e'(enc) == ENC_LEGACY;
    evex     = enc_e'(enc) == ENC_EVEX;
    splat_b  = evex && mem_src && bcast;
    mask_use = evex && mask_en;
    if (legacy || vlen == 2'd0) n_active = CNT_W'(2);
    else if (vlen == 2'd1)      n_active = CNT_W'(4);
    else                        n_active = CNT_W'(LANES);
  end

  lane_operand_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_ops (
    .legacy (legacy),
    .splat_b(splat_b),
    .src_a  (src_a),
    .src_b  (src_b),
    .old_dst(old_dst),
    .op_a   (op_a),
    .op_b   (op_b)
  );

  lane_rc_select u_rc (
    .enc      (enc),
    .vlen     (vlen),
    .reg_src  (reg_src),
    .bcast    (bcast),
    .rc_global(rc_global),
    .rc_embed (rc_embed),
    .rc_sel   (rc_sel)
  );

  lane_dest_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .n_active (n_active),
    .legacy   (legacy),
    .mask_use (mask_use),
    .zero_mode(zero_mode),
    .wmask    (wmask),
    .old_dst  (old_dst),
    .lane_sum (lane_sum),
    .next_dst (next_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= next_dst;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(dst)));

  // R8
  legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc == 2'd0) |=>
      dst[VEC_W-1:2*LANE_W] == $past(old_dst[VEC_W-1:2*LANE_W]));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc != 2'd0 && vlen == 2'd0) |=> dst[VEC_W-1:2*LANE_W] == '0);

  // R4
  zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc == 2'd2 && mask_en && zero_mode && !wmask[0]) |=>
      dst[LANE_W-1:0] == '0);

  // R6
  bcast_op_chk: assert property (@(posedge clk) disable iff (rst)
    (enc == 2'd2 && mem_src && bcast) |-> op_b[VEC_W-1 -: LANE_W] == src_b[LANE_W-1:0]);

  // R9
  rc_default_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_src |-> rc_sel == rc_global);
endmodule

// File: tb/vec_lane_merge_test.sv
module vec_lane_merge_test;
  localparam int L = 8;
  localparam int W = 64;
  localparam int V = L * W;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] vlen = '0, enc = '0, rc_global = '0, rc_embed = '0;
  logic bcast = 0, mem_src = 0, reg_src = 0, mask_en = 0, zero_mode = 0;
  logic [L-1:0] wmask = '0;
  logic [V-1:0] src_a = '0, src_b = '0, old_dst = '0, lane_sum;
  logic [V-1:0] op_a, op_b, dst;
  logic [1:0] rc_sel;
  logic out_valid;

  int checks = 0, fails = 0, cycles = 0;

  vec_lane_merge uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vlen(vlen), .enc(enc),
    .bcast(bcast), .mem_src(mem_src), .reg_src(reg_src), .wmask(wmask),
    .mask_en(mask_en), .zero_mode(zero_mode), .rc_global(rc_global),
    .rc_embed(rc_embed), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .lane_sum(lane_sum), .op_a(op_a), .op_b(op_b), .rc_sel(rc_sel),
    .dst(dst), .out_valid(out_valid)
  );

  always #5 clk = ~clk;

  // stand-in adders: integer lane sums of the operand buses
  always_comb begin
    for (int j = 0; j < L; j++)
      lane_sum[j*W +: W] = op_a[j*W +: W] + op_b[j*W +: W];
  end

  task automatic chk(input bit ok, input string tag, input logic [V-1:0] act,
                     input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [V-1:0] rnd_vec();
    logic [V-1:0] r;
    for (int k = 0; k < V / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic apply(input logic [1:0] vl, input logic [1:0] e, input bit bc,
                       input bit ms, input bit rs, input logic [L-1:0] wm,
                       input bit me, input bit zm, input string tag);
    logic [V-1:0] ea, eb, ed, prev;
    logic [W-1:0] s;
    logic [1:0] erc;
    int n;
    @(negedge clk);
    vlen = vl; enc = e; bcast = bc; mem_src = ms; reg_src = rs; wmask = wm;
    mask_en = me; zero_mode = zm; rc_global = 2'($urandom); rc_embed = 2'($urandom);
    src_a = rnd_vec(); src_b = rnd_vec(); old_dst = rnd_vec(); in_valid = 1'b1;
    n = (e == 2'd0 || vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    for (int j = 0; j < L; j++) begin
      ea[j*W +: W] = (e == 2'd0) ? old_dst[j*W +: W] : src_a[j*W +: W];
      eb[j*W +: W] = (e == 2'd2 && ms && bc) ? src_b[W-1:0] : src_b[j*W +: W];
      s = ea[j*W +: W] + eb[j*W +: W];
      if (j >= n)
        ed[j*W +: W] = (e == 2'd0) ? old_dst[j*W +: W] : '0;
      else if (e != 2'd2 || !me || wm[j])
        ed[j*W +: W] = s;
      else
        ed[j*W +: W] = zm ? '0 : old_dst[j*W +: W];
    end
    erc = (e == 2'd2 && rs && vl[1] && bc) ? rc_embed : rc_global;
    #1;
    chk(op_a == ea, {tag, " R12/R8 op_a"}, op_a, ea);
    chk(op_b == eb, {tag, " R12/R6 op_b"}, op_b, eb);
    chk(rc_sel == erc, "R9 rc_sel", V'(rc_sel), V'(erc));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R10 strobe", V'(out_valid), V'(1));
    chk(dst == ed, {tag, " dst"}, dst, ed);
    prev = dst;
    old_dst = rnd_vec();
    @(negedge clk);
    chk(out_valid == 1'b0 && dst == prev, "R10 hold", dst, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dst == '0 && out_valid == 1'b0, "R11 reset", dst, '0);
    rst = 1'b0;
    apply(2'd0, 2'd1, 0, 0, 1, 8'h00, 1, 1, "R5 R7 R1 vex128");
    apply(2'd1, 2'd1, 0, 0, 1, 8'h5A, 1, 0, "R5 R7 vex256");
    apply(2'd2, 2'd1, 0, 0, 1, 8'h00, 1, 1, "R5 vex512");
    apply(2'd2, 2'd2, 0, 0, 1, 8'hA5, 1, 0, "R2 R3 evex merge");
    apply(2'd2, 2'd2, 0, 0, 1, 8'h3C, 1, 1, "R2 R4 evex zero");
    apply(2'd1, 2'd2, 0, 0, 1, 8'h00, 0, 1, "R2 evex nomask");
    apply(2'd1, 2'd2, 1, 1, 0, 8'hF6, 1, 1, "R6 R1 evex256 bcast");
    apply(2'd0, 2'd2, 0, 0, 1, 8'hFD, 1, 0, "R1 R7 evex128");
    apply(2'd0, 2'd0, 0, 0, 1, 8'h00, 1, 1, "R8 legacy");
    apply(2'd2, 2'd2, 1, 0, 1, 8'hFF, 0, 0, "R9 embed");
    apply(2'd1, 2'd2, 1, 0, 1, 8'hFF, 0, 0, "R9 len256");
    apply(2'd2, 2'd2, 1, 1, 0, 8'hFF, 0, 0, "R9 R6 mem bcast");
    apply(2'd3, 2'd3, 1, 0, 1, 8'h0F, 1, 1, "R5 R1 code3");
    for (int t = 0; t < 200; t++)
      apply(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            "R2 R3 R4 R7 R8 random");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule